// File: doc/BRIEF.md
# SDRAM Refresh Deadline Tracker

This block watches the command bus of a synchronous DRAM and checks that the memory gets enough refresh. The array has four banks of 4096 rows. On every rising clock edge it decodes the chip-select, row-strobe, column-strobe, write-enable and clock-enable lines. It counts auto-refresh commands inside a refresh window of programmable length. A window that closes with too few refreshes is a lost-data hazard. The block records such a window in a violation flag that stays set until reset.

The memory may also be placed in self-refresh, which refreshes it without commands on the bus. While the tracker sees the device in self-refresh, the deadline is suspended. When the device leaves self-refresh, a new window starts from zero.

An urgency output warns a command scheduler ahead of the deadline. It asserts when the cycles left in the window are fewer than a programmable margin multiplied by the refreshes still owed.

The controller has three states:
- `ST_TRACK`: the window is running and the quota is not yet met.
- `ST_MET`: the quota is met and the window runs to its end.
- `ST_SELF`: the device is in self-refresh.

The transitions are:
- `T_QUOTA`: `ST_TRACK` to `ST_MET`, when the count reaches the quota.
- `T_WIN_PASS`: the window closes after the quota was met. The block goes to `ST_TRACK` with the counters cleared.
- `T_WIN_FAIL`: the window closes in `ST_TRACK`. The block stays in `ST_TRACK`, clears the counters and sets the violation flag.
- `T_SR_ENTER`: `ST_TRACK` or `ST_MET` to `ST_SELF`.
- `T_SR_EXIT`: `ST_SELF` to `ST_TRACK`.

Top module: `refresh_deadline_tracker`

## Requirements
- R1: An auto-refresh command is sampled at a rising edge with all of these true: `cke`=1, `cs_n`=0, `ras_n`=0, `cas_n`=0, `we_n`=1. Any other combination with `cke`=1 adds nothing to the refresh count.
- R2: The window lasts `WINDOW_CYCLES` rising edges. It starts at the first edge after reset, after a window close, or after self-refresh exit. Commands at all of those edges count, including the last edge.
- R3: The refresh count saturates at `REFRESH_QUOTA`. Reaching it moves the block to `ST_MET`.
- R4: A window that closes with the quota met leaves `violation` unchanged. The next window starts with a count of zero.
- R5: A window that closes in `ST_TRACK` with fewer than `REFRESH_QUOTA` refreshes sets `violation` at that closing edge, and at no other time.
- R6: `violation` stays high until reset, whatever refresh activity follows.
- R7: Self-refresh entry has the auto-refresh pattern with `cke`=0. From entry until exit, the window and count are held at zero, no window can close, and `violation` cannot be set.
- R8: Self-refresh exit occurs at the first edge in `ST_SELF` where `cke`=1. A fresh window then starts with zero refreshes counted; refreshes from before entry are not carried over.
- R9: `urgent` is high exactly when the block is in `ST_TRACK` and (`WINDOW_CYCLES`-1-window position) < `URGENCY_MARGIN` × (`REFRESH_QUOTA` - count). It is low in `ST_MET` and `ST_SELF`.
- R10: After reset the block is in `ST_TRACK` with both counters at zero, and `violation` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Memory command clock; commands are sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable seen by the memory |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| urgent | output | 1 | Refresh deadline is close relative to the outstanding count |
| violation | output | 1 | Sticky flag: a window closed short of its quota |

## Verification
Some properties are checked by the assertions on every cycle:
- The window position stays bounded.
- The count never exceeds the quota.
- `ST_MET` always holds a full count.
- Self-refresh keeps both counters at zero and `urgent` low.
- `violation` rises only at a closing edge of a short window, and never falls.

Other behaviours only the directed scenarios can show:
- Exactly which bus patterns count as refreshes.
- The precise edge on which a short window is flagged.
- The threshold crossing of `urgent`.
- That self-refresh exit really discards earlier refreshes and restarts timing.

// File: rtl/rdt_pkg.sv
package rdt_pkg;

    typedef enum logic [1:0] {
        ST_TRACK = 2'd0,
        ST_MET   = 2'd1,
        ST_SELF  = 2'd2
    } rdt_state_e;

    typedef struct packed {
        logic auto_ref;
        logic sr_enter;
    } rdt_cmd_t;

endpackage

// File: rtl/rdt_cmd_decode.sv
module rdt_cmd_decode
    import rdt_pkg::*;
(
    input  logic     cke,
    input  logic     cs_n,
    input  logic     ras_n,
    input  logic     cas_n,
    input  logic     we_n,
    output rdt_cmd_t cmd
);

    logic ref_pattern;

    always_comb begin
        ref_pattern  = !cs_n && !ras_n && !cas_n && we_n;
        cmd.auto_ref = ref_pattern && cke;
        cmd.sr_enter = ref_pattern && !cke;
    end

endmodule

// File: rtl/rdt_counters.sv
module rdt_counters #(
    parameter int WINDOW_CYCLES = 6400000,
    parameter int REFRESH_QUOTA = 4096,
    localparam int WIN_W = $clog2(WINDOW_CYCLES),
    localparam int REF_W = $clog2(REFRESH_QUOTA + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_clr,
    input  logic             auto_ref,
    output logic [WIN_W-1:0] win_cnt,
    output logic [REF_W-1:0] ref_cnt,
    output logic             win_last,
    output logic             quota_next
);

    localparam logic [WIN_W-1:0] WIN_END  = WIN_W'(WINDOW_CYCLES - 1);
    localparam logic [REF_W-1:0] QUOTA    = REF_W'(REFRESH_QUOTA);
    localparam logic [REF_W-1:0] QUOTA_M1 = REF_W'(REFRESH_QUOTA - 1);

    always_comb begin
        win_last   = (win_cnt == WIN_END);
        quota_next = (ref_cnt == QUOTA) || (auto_ref && (ref_cnt == QUOTA_M1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_cnt <= '0;
        end else if (cnt_clr) begin
            win_cnt <= '0;
        end else begin
            win_cnt <= win_cnt + WIN_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_cnt <= '0;
        end else if (cnt_clr) begin
            ref_cnt <= '0;
        end else if (auto_ref && (ref_cnt != QUOTA)) begin
            ref_cnt <= ref_cnt + REF_W'(1);
        end
    end

endmodule

// File: rtl/rdt_fsm.sv
module rdt_fsm
    import rdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  rdt_cmd_t   cmd,
    input  logic       cke,
    input  logic       win_last,
    input  logic       quota_next,
    output rdt_state_e state,
    output logic       cnt_clr,
    output logic       violation
);

    rdt_state_e state_nxt;
    logic       viol_set;

    // Next-state selection; self-refresh entry outranks a window close.
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_TRACK: begin
                if (cmd.sr_enter)        state_nxt = ST_SELF;   // T_SR_ENTER
                else if (win_last)       state_nxt = ST_TRACK;  // T_WIN_FAIL / pass on last edge
                else if (quota_next)     state_nxt = ST_MET;    // T_QUOTA
                else                     state_nxt = ST_TRACK;
            end
            ST_MET: begin
                if (cmd.sr_enter)        state_nxt = ST_SELF;   // T_SR_ENTER
                else if (win_last)       state_nxt = ST_TRACK;  // T_WIN_PASS
                else                     state_nxt = ST_MET;
            end
            ST_SELF: begin
                if (cke)                 state_nxt = ST_TRACK;  // T_SR_EXIT
                else                     state_nxt = ST_SELF;
            end
            default:                     state_nxt = ST_TRACK;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_TRACK;
        else        state <= state_nxt;
    end

    // Output decode from the current state and sampled events.
    always_comb begin
        cnt_clr  = (state == ST_SELF) || cmd.sr_enter || win_last;
        viol_set = (state == ST_TRACK) && win_last && !cmd.sr_enter && !quota_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        violation <= 1'b0;
        else if (viol_set) violation <= 1'b1;
    end

endmodule

// File: rtl/rdt_urgency.sv
module rdt_urgency
    import rdt_pkg::*;
#(
    parameter int WINDOW_CYCLES  = 6400000,
    parameter int REFRESH_QUOTA  = 4096,
    parameter int URGENCY_MARGIN = 16,
    localparam int WIN_W  = $clog2(WINDOW_CYCLES),
    localparam int REF_W  = $clog2(REFRESH_QUOTA + 1),
    localparam int MARG_W = $clog2(URGENCY_MARGIN + 1),
    localparam int PROD_W = MARG_W + REF_W,
    localparam int CMP_W  = ((WIN_W > PROD_W) ? WIN_W : PROD_W) + 1
) (
    input  rdt_state_e       state,
    input  logic [WIN_W-1:0] win_cnt,
    input  logic [REF_W-1:0] ref_cnt,
    output logic             urgent
);

    logic [CMP_W-1:0] remaining;
    logic [CMP_W-1:0] owed;
    logic [CMP_W-1:0] needed;

    always_comb begin
        remaining = CMP_W'(WINDOW_CYCLES - 1) - CMP_W'(win_cnt);
        owed      = CMP_W'(REFRESH_QUOTA) - CMP_W'(ref_cnt);
        needed    = CMP_W'(URGENCY_MARGIN) * owed;
        urgent    = (state == ST_TRACK) && (remaining < needed);
    end

endmodule

// File: rtl/refresh_deadline_tracker.sv
module refresh_deadline_tracker
    import rdt_pkg::*;
#(
    parameter int WINDOW_CYCLES  = 6400000,
    parameter int REFRESH_QUOTA  = 4096,
    parameter int URGENCY_MARGIN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cke,
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output logic urgent,
    output logic violation
);

    localparam int WIN_W = $clog2(WINDOW_CYCLES);
    localparam int REF_W = $clog2(REFRESH_QUOTA + 1);

    rdt_cmd_t         cmd;
    rdt_state_e       state;
    logic             cnt_clr;
    logic             win_last;
    logic             quota_next;
    logic [WIN_W-1:0] win_cnt;
    logic [REF_W-1:0] ref_cnt;

    rdt_cmd_decode u_decode (
        .cke   (cke),
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cmd   (cmd)
    );

    rdt_counters #(
        .WINDOW_CYCLES (WINDOW_CYCLES),
        .REFRESH_QUOTA (REFRESH_QUOTA)
    ) u_counters (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt_clr    (cnt_clr),
        .auto_ref   (cmd.auto_ref),
        .win_cnt    (win_cnt),
        .ref_cnt    (ref_cnt),
        .win_last   (win_last),
        .quota_next (quota_next)
    );

    rdt_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd        (cmd),
        .cke        (cke),
        .win_last   (win_last),
        .quota_next (quota_next),
        .state      (state),
        .cnt_clr    (cnt_clr),
        .violation  (violation)
    );

    rdt_urgency #(
        .WINDOW_CYCLES  (WINDOW_CYCLES),
        .REFRESH_QUOTA  (REFRESH_QUOTA),
        .URGENCY_MARGIN (URGENCY_MARGIN)
    ) u_urgency (
        .state   (state),
        .win_cnt (win_cnt),
        .ref_cnt (ref_cnt),
        .urgent  (urgent)
    );

endmodule

// File: rtl/refresh_deadline_tracker_chk.sv
module refresh_deadline_tracker_chk
    import rdt_pkg::*;
#(
    parameter int WINDOW_CYCLES  = 6400000,
    parameter int REFRESH_QUOTA  = 4096,
    localparam int WIN_W = $clog2(WINDOW_CYCLES),
    localparam int REF_W = $clog2(REFRESH_QUOTA + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input rdt_state_e       state,
    input logic [WIN_W-1:0] win_cnt,
    input logic [REF_W-1:0] ref_cnt,
    input logic             urgent,
    input logic             violation
);

    AST_WIN_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        win_cnt <= WIN_W'(WINDOW_CYCLES - 1));                                  // R2

    AST_COUNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        ref_cnt <= REF_W'(REFRESH_QUOTA));                                     // R3

    AST_MET_IS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MET) |-> (ref_cnt == REF_W'(REFRESH_QUOTA)));             // R3

    AST_VIOL_ONLY_ON_SHORT_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(violation) |-> ($past(state) == ST_TRACK &&
                              $past(win_cnt) == WIN_W'(WINDOW_CYCLES - 1)));   // R5

    AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        violation |=> violation);                                              // R6

    AST_SELF_HOLDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SELF) |-> (win_cnt == '0 && ref_cnt == '0));              // R7

    AST_NO_URGENT_OUTSIDE_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_TRACK) |-> !urgent);                                      // R9

endmodule

bind refresh_deadline_tracker refresh_deadline_tracker_chk #(
    .WINDOW_CYCLES (WINDOW_CYCLES),
    .REFRESH_QUOTA (REFRESH_QUOTA)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state),
    .win_cnt   (win_cnt),
    .ref_cnt   (ref_cnt),
    .urgent    (urgent),
    .violation (violation)
);

// File: tb/refresh_deadline_tracker_tb.sv
`timescale 1ns/1ps
module refresh_deadline_tracker_tb;

    localparam int W  = 200;
    localparam int Q  = 8;
    localparam int M  = 4;
    localparam real HALF = 4.0;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic urgent, violation;

    int n_vec = 0;
    int n_bad = 0;

    always #(HALF) clk = ~clk;

    refresh_deadline_tracker #(
        .WINDOW_CYCLES  (W),
        .REFRESH_QUOTA  (Q),
        .URGENCY_MARGIN (M)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .cke (cke), .cs_n (cs_n),
        .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n),
        .urgent (urgent), .violation (violation)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic bus(input logic k, input logic c, input logic r, input logic a, input logic w);
        cke = k; cs_n = c; ras_n = r; cas_n = a; we_n = w;
    endtask

    task automatic idle(input int n);
        bus(1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
        repeat (n) @(negedge clk);
    endtask

    task automatic refreshes(input int n);
        for (int i = 0; i < n; i++) begin
            bus(1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
            @(negedge clk);
        end
        bus(1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_state();
        do_reset();
        check("R10 violation after reset", violation, 1'b0);
        check("R10 urgent after reset", urgent, 1'b0);
    endtask

    task automatic t_quota_met();
        refreshes(Q);
        check("R3 urgent low once quota met", urgent, 1'b0);
        idle(W - Q - 1);
        check("R4 no violation before close", violation, 1'b0);
        idle(1);
        check("R4 no violation after full window", violation, 1'b0);
    endtask

    task automatic t_urgency_and_miss();
        idle(167);
        check("R9 urgent low at remaining 32", urgent, 1'b0);
        idle(1);
        check("R9 urgent high at remaining 31", urgent, 1'b1);
        refreshes(1);
        check("R9 urgent drops with one less owed", urgent, 1'b0);
        idle(30);
        check("R5 not flagged before last edge", violation, 1'b0);
        idle(1);
        check("R5 short window flagged on close", violation, 1'b1);
    endtask

    task automatic t_sticky();
        refreshes(Q);
        idle(W - Q);
        check("R6 violation stays after good window", violation, 1'b1);
    endtask

    task automatic t_ignored_cmds();
        do_reset();
        for (int i = 0; i < Q; i++) begin
            unique case (i % 4)
                0: bus(1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
                1: bus(1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
                2: bus(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
                default: bus(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
            endcase
            @(negedge clk);
        end
        idle(W - Q - 1);
        check("R1 other patterns not counted (urgent)", urgent, 1'b1);
        idle(1);
        check("R1 other patterns not counted (violation)", violation, 1'b1);
    endtask

    task automatic t_self_refresh();
        do_reset();
        refreshes(2);
        bus(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        @(negedge clk);
        bus(1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
        repeat (3 * W) @(negedge clk);
        check("R7 no violation during self-refresh", violation, 1'b0);
        check("R7 urgent low during self-refresh", urgent, 1'b0);
        idle(1);
        check("R8 urgent low at fresh window start", urgent, 1'b0);
        refreshes(Q - 1);
        idle(W - Q);
        check("R8 window timed from exit", violation, 1'b0);
        idle(1);
        check("R8 pre-entry refreshes discarded", violation, 1'b1);
    endtask

    initial begin
        #(HALF * 2.0 * 150000.0);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset_state();
        t_quota_met();
        t_urgency_and_miss();
        t_sticky();
        t_ignored_cmds();
        t_self_refresh();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule